// File: doc/BRIEF.md
# Synchronized Timestamp Receiver

This block sits in a front-end and keeps a coarse timestamp counter and a fine time counter that stay aligned with a central trigger processor. Both counters advance by one on every clock. The processor aligns them by sending an accept strobe together with a broadcast message whose code means "zero your counters". When that pair is seen, both counters restart from zero at that clock edge. After that, a strobe seen at coarse value TS is known to have left the sender when the sender's own counter also read TS.

Each sender delays every accept by a fixed offset that all parties know. For each ordinary accept, the block therefore reports a reference timestamp equal to the current coarse reading minus that offset. The report goes out as a one-cycle event record, which also carries the fine time. An accept that arrives before the counters have ever been aligned produces no record. Instead it raises a status flag that says the receiver is not synchronized.

A three-state controller sets the behaviour. The states are UNSYNCED (out of reset, no alignment yet), ALARM (a stray accept arrived while unaligned) and LOCKED (aligned). It has these transitions:
- SYNC_CMD takes UNSYNCED or ALARM to LOCKED.
- STRAY_ACCEPT takes UNSYNCED to ALARM.
- RESYNC keeps LOCKED in LOCKED and re-zeroes the counters.
- Every other input pattern holds the current state.

Top module: `ts_sync_rx`

## Requirements
- R1: While reset is held and in the first cycle after it is released, coarse and fine read 0, event valid is 0 and the not-synchronized flag is 0.
- R2: The coarse counter increases by one every clock and wraps from 2^TS_W-1 to 0.
- R3: The fine counter increases by one every clock and wraps from 2^FT_W-1 to 0.
- R4: A reset command is accept=1, msg_valid=1 and msg_code equal to the configured 6-bit reset code in the same cycle. One cycle later, both counters read 0, and they count on from 0.
- R5: An accept with msg_valid low, or with a message code different from the reset code, leaves both counters counting normally.
- R6: In LOCKED, an accept that is not a reset command gives evt_valid=1 in the next cycle for exactly that cycle. evt_ts then equals (coarse at the accept cycle − send offset) mod 2^TS_W.
- R7: evt_ft carries the fine counter value from the accept cycle.
- R8: A reset command never produces an event record (evt_valid stays 0 in the following cycle).
- R9: Before the first reset command, an accept produces no event. From the next cycle, unsync stays 1 until a reset command arrives.
- R10: A reset command clears unsync in the next cycle, and later ordinary accepts produce events.
- R11: msg_valid without accept, even carrying the reset code, has no effect on the counters, the flag or the event output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one coarse tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | Accept strobe from the trigger processor |
| msg_valid_i | input | 1 | Broadcast message present this cycle |
| msg_code_i | input | MSG_W | Broadcast message code |
| reset_code_i | input | MSG_W | Configured code meaning "zero the counters" |
| send_offset_i | input | TS_W | Fixed send latency to subtract |
| coarse_o | output | TS_W | Coarse timestamp counter |
| fine_o | output | FT_W | Fine time counter |
| evt_valid_o | output | 1 | One-cycle event record valid |
| evt_ts_o | output | TS_W | Reference timestamp of the event |
| evt_ft_o | output | FT_W | Fine time of the event |
| unsync_o | output | 1 | Accept seen before any alignment |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- the counter values after a reset command
- the event record, with its timestamp and fine time
- the flag change

The bench drives inputs just after a falling edge. It advances its arithmetic model at the same moment and compares the outputs at the next falling edge, one rising edge later. It sweeps every send offset of a small configuration, with several accept spacings and back-to-back accepts, so the subtraction wraps in both directions.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    typedef enum logic [1:0] {
        ST_UNSYNCED = 2'd0,
        ST_ALARM    = 2'd1,
        ST_LOCKED   = 2'd2
    } tsr_state_e;

endpackage

// File: rtl/tsr_wrap_counter.sv
module tsr_wrap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] STEP = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clear) begin
            value <= '0;
        end else begin
            value <= value + STEP;
        end
    end
endmodule

// File: rtl/tsr_sync_fsm.sv
module tsr_sync_fsm
    import tsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_cmd,
    input  logic plain_accept,
    output logic locked,
    output logic unsync,
    output logic fire_event
);
    tsr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNSYNCED: begin
                if (sync_cmd)          state_d = ST_LOCKED;
                else if (plain_accept) state_d = ST_ALARM;
            end
            ST_ALARM: begin
                if (sync_cmd)          state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                state_d = ST_LOCKED;
            end
            default: state_d = ST_UNSYNCED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNSYNCED;
        else        state_q <= state_d;
    end

    always_comb begin
        locked     = 1'b0;
        unsync     = 1'b0;
        fire_event = 1'b0;
        unique case (state_q)
            ST_UNSYNCED: ;
            ST_ALARM:    unsync = 1'b1;
            ST_LOCKED: begin
                locked     = 1'b1;
                fire_event = plain_accept;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tsr_event_fmt.sv
module tsr_event_fmt #(
    parameter int TS_W = 16,
    parameter int FT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [TS_W-1:0] coarse,
    input  logic [FT_W-1:0] fine,
    input  logic [TS_W-1:0] offset,
    output logic            evt_valid,
    output logic [TS_W-1:0] evt_ts,
    output logic [FT_W-1:0] evt_ft
);
    logic [TS_W-1:0] ref_ts;

    always_comb ref_ts = coarse - offset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_ts    <= '0;
            evt_ft    <= '0;
        end else begin
            evt_valid <= fire;
            if (fire) begin
                evt_ts <= ref_ts;
                evt_ft <= fine;
            end
        end
    end
endmodule

// File: rtl/ts_sync_rx.sv
module ts_sync_rx #(
    parameter int TS_W  = 16,
    parameter int FT_W  = 8,
    parameter int MSG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             msg_valid_i,
    input  logic [MSG_W-1:0] msg_code_i,
    input  logic [MSG_W-1:0] reset_code_i,
    input  logic [TS_W-1:0]  send_offset_i,
    output logic [TS_W-1:0]  coarse_o,
    output logic [FT_W-1:0]  fine_o,
    output logic             evt_valid_o,
    output logic [TS_W-1:0]  evt_ts_o,
    output logic [FT_W-1:0]  evt_ft_o,
    output logic             unsync_o
);
    logic sync_cmd;
    logic plain_accept;
    logic locked;
    logic fire_event;

    always_comb begin
        sync_cmd     = accept_i && msg_valid_i && (msg_code_i == reset_code_i);
        plain_accept = accept_i && !sync_cmd;
    end

    tsr_sync_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_cmd     (sync_cmd),
        .plain_accept (plain_accept),
        .locked       (locked),
        .unsync       (unsync_o),
        .fire_event   (fire_event)
    );

    tsr_wrap_counter #(.W(TS_W)) u_coarse (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sync_cmd),
        .value (coarse_o)
    );

    tsr_wrap_counter #(.W(FT_W)) u_fine (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sync_cmd),
        .value (fine_o)
    );

    tsr_event_fmt #(.TS_W(TS_W), .FT_W(FT_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire_event),
        .coarse    (coarse_o),
        .fine      (fine_o),
        .offset    (send_offset_i),
        .evt_valid (evt_valid_o),
        .evt_ts    (evt_ts_o),
        .evt_ft    (evt_ft_o)
    );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
    parameter int TS_W  = 16,
    parameter int FT_W  = 8,
    parameter int MSG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept_i,
    input logic             msg_valid_i,
    input logic [MSG_W-1:0] msg_code_i,
    input logic [MSG_W-1:0] reset_code_i,
    input logic [TS_W-1:0]  send_offset_i,
    input logic [TS_W-1:0]  coarse_o,
    input logic [FT_W-1:0]  fine_o,
    input logic             evt_valid_o,
    input logic [TS_W-1:0]  evt_ts_o,
    input logic [FT_W-1:0]  evt_ft_o,
    input logic             unsync_o,
    input logic             locked
);
    logic cmd_seen;
    assign cmd_seen = accept_i && msg_valid_i && (msg_code_i == reset_code_i);

    // R4
    counters_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |=> (coarse_o == '0) && (fine_o == '0));

    // R2
    coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_seen |=> coarse_o == TS_W'($past(coarse_o) + 1'b1));

    // R3
    fine_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_seen |=> fine_o == FT_W'($past(fine_o) + 1'b1));

    // R6
    event_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !cmd_seen && locked) |=>
            evt_valid_o && (evt_ts_o == TS_W'($past(coarse_o) - $past(send_offset_i))));

    // R7
    event_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !cmd_seen && locked) |=> evt_ft_o == $past(fine_o));

    // R8
    no_event_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |=> !evt_valid_o);

    // R9
    stray_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !cmd_seen && !locked) |=> unsync_o && !evt_valid_o);

    // R10
    flag_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |=> !unsync_o && locked);
endmodule

bind ts_sync_rx tsr_checker #(.TS_W(TS_W), .FT_W(FT_W), .MSG_W(MSG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept_i),
    .msg_valid_i   (msg_valid_i),
    .msg_code_i    (msg_code_i),
    .reset_code_i  (reset_code_i),
    .send_offset_i (send_offset_i),
    .coarse_o      (coarse_o),
    .fine_o        (fine_o),
    .evt_valid_o   (evt_valid_o),
    .evt_ts_o      (evt_ts_o),
    .evt_ft_o      (evt_ft_o),
    .unsync_o      (unsync_o),
    .locked        (locked)
);

// File: tb/sim_ts_sync_rx.sv
module sim_ts_sync_rx;
    localparam int PERIOD = 10;
    localparam int TS_W  = 5;
    localparam int FT_W  = 3;
    localparam int MSG_W = 6;
    localparam logic [MSG_W-1:0] RCODE = 6'h2A;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             accept_i = 1'b0;
    logic             msg_valid_i = 1'b0;
    logic [MSG_W-1:0] msg_code_i = '0;
    logic [MSG_W-1:0] reset_code_i = RCODE;
    logic [TS_W-1:0]  send_offset_i = '0;
    logic [TS_W-1:0]  coarse_o;
    logic [FT_W-1:0]  fine_o;
    logic             evt_valid_o;
    logic [TS_W-1:0]  evt_ts_o;
    logic [FT_W-1:0]  evt_ft_o;
    logic             unsync_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [TS_W-1:0] m_c = '0;
    logic [FT_W-1:0] m_f = '0;
    logic            m_lock = 1'b0;
    logic            m_un = 1'b0;
    logic            m_v = 1'b0;
    logic [TS_W-1:0] m_ts = '0;
    logic [FT_W-1:0] m_ft = '0;

    always #(PERIOD/2) clk = ~clk;

    ts_sync_rx #(.TS_W(TS_W), .FT_W(FT_W), .MSG_W(MSG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .msg_valid_i(msg_valid_i),
        .msg_code_i(msg_code_i), .reset_code_i(reset_code_i), .send_offset_i(send_offset_i),
        .coarse_o(coarse_o), .fine_o(fine_o), .evt_valid_o(evt_valid_o),
        .evt_ts_o(evt_ts_o), .evt_ft_o(evt_ft_o), .unsync_o(unsync_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus, advance the model, check one edge later.
    task automatic cyc(input bit acc, input bit mv, input logic [MSG_W-1:0] code,
                       input logic [TS_W-1:0] off);
        bit rcmd;
        string ctag, ftag, vtag, utag;
        rcmd = acc && mv && (code == RCODE);
        accept_i = acc; msg_valid_i = mv; msg_code_i = code; send_offset_i = off;
        m_v  = acc && !rcmd && m_lock;
        m_ts = m_c - off;
        m_ft = m_f;
        if (rcmd) m_un = 1'b0;
        else if (acc && !m_lock) m_un = 1'b1;
        if (rcmd) m_lock = 1'b1;
        m_c = rcmd ? '0 : m_c + 1'b1;
        m_f = rcmd ? '0 : m_f + 1'b1;
        ctag = rcmd ? "R4" : (acc ? "R5" : (mv ? "R11" : "R2"));
        ftag = rcmd ? "R4" : (acc ? "R5" : (mv ? "R11" : "R3"));
        vtag = rcmd ? "R8" : (m_v ? "R6" : (acc ? "R9" : "R11"));
        utag = rcmd ? "R10" : "R9";
        @(posedge clk);
        @(negedge clk);
        accept_i = 1'b0; msg_valid_i = 1'b0;
        chk(ctag, int'(coarse_o), int'(m_c));
        chk(ftag, int'(fine_o), int'(m_f));
        chk(vtag, int'(evt_valid_o), int'(m_v));
        chk(utag, int'(unsync_o), int'(m_un));
        if (m_v) begin
            chk("R6", int'(evt_ts_o), int'(m_ts));
            chk("R7", int'(evt_ft_o), int'(m_ft));
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", int'(coarse_o), 0);
        chk("R1", int'(fine_o), 0);
        chk("R1", int'(evt_valid_o), 0);
        chk("R1", int'(unsync_o), 0);
        rst_n = 1'b1;
        // R1 first cycle after release (checked before the next edge)
        #1;
        chk("R1", int'(coarse_o), 0);
        chk("R1", int'(unsync_o), 0);
        // free run past both wraps: R2, R3
        for (int i = 0; i < 40; i++) cyc(0, 0, '0, '0);
        // R11: message with reset code but no accept
        cyc(0, 1, RCODE, 5'd3);
        cyc(0, 1, 6'h11, 5'd3);
        // R5/R9: accepts before any alignment
        cyc(1, 0, RCODE, 5'd3);
        cyc(0, 0, '0, 5'd3);
        cyc(1, 1, 6'h2B, 5'd3);
        for (int i = 0; i < 3; i++) cyc(0, 0, '0, 5'd3);
        // R4/R10: alignment
        cyc(1, 1, RCODE, 5'd3);
        for (int i = 0; i < 4; i++) cyc(0, 0, '0, 5'd3);
        // Sweep every offset with varied spacing and back-to-back accepts: R6, R7
        for (int off = 0; off < (1 << TS_W); off++) begin
            for (int gap = 0; gap < 5; gap++) begin
                for (int g = 0; g < gap; g++) cyc(0, 0, '0, TS_W'(off));
                cyc(1, (gap % 2) == 1, 6'(gap + 1), TS_W'(off));
            end
            cyc(1, 0, '0, TS_W'(off));
            cyc(1, 0, '0, TS_W'(off));
            // R4/R8: realign mid-stream every few offsets
            if ((off % 3) == 0) cyc(1, 1, RCODE, TS_W'(off));
            cyc(0, 1, RCODE, TS_W'(off));
        end
        // back-to-back realign then accept
        cyc(1, 1, RCODE, 5'd31);
        cyc(1, 0, '0, 5'd31);
        cyc(0, 0, '0, 5'd31);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule